// File: doc/BRIEF.md
# Checkpoint Beep Code Sequencer

This block turns an 8-bit progress checkpoint into a pattern on one speaker-enable line, so that a fault can be identified by ear before any display works. On a start strobe the checkpoint is captured and cut into four 2-bit fields. The most significant field is played first. Each field plays as a run of beeps, and the number of beeps is the field value plus one. A short silence separates beeps inside a run. A longer silence separates one run from the next.

Three parameters set the timing, each as a count of clock cycles: the beep length (`ON_CYC`), the gap inside a run (`INTRA_CYC`) and the gap between runs (`GROUP_CYC`). While a pattern plays, `busy` is high. When the last beep ends, `done` pulses for one cycle. No trailing pause follows the fourth run. Tone generation belongs to the circuit that `spk` gates, and is not part of this block.

Top module: `beep_code_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle has `spk`, `busy` and `done` all low. After reset the block is idle.
- R2: Each beep holds `spk` high for exactly `ON_CYC` cycles. Beeps within one run are separated by exactly `INTRA_CYC` low cycles.
- R3: Runs play from bits [7:6] down to bits [1:0]. A run has (field value + 1) beeps, so field value 0 gives 1 beep and field value 3 gives 4 beeps. Checkpoint 0x4B plays 2-1-3-4.
- R4: Checkpoint 0x20 plays 1-3-1-1, and checkpoint 0x16 plays 1-2-2-3.
- R5: Every checkpoint gives exactly four runs, and every run has at least one beep. Checkpoint 0x00 plays 1-1-1-1 and 0xFF plays 4-4-4-4.
- R6: Consecutive runs are separated by exactly `GROUP_CYC` low cycles on `spk`. `GROUP_CYC` is larger than `INTRA_CYC`.
- R7: An accepted start raises `busy` and `spk` in the next cycle. `busy` stays high through the last beep. In the cycle after the last beep, `done` is high for one cycle with `busy` and `spk` low. No trailing gap is added.
- R8: The checkpoint is sampled only on an accepted start. A start while `busy` is high is ignored, and changes on `code` during playback have no effect.
- R9: A synchronous reset during playback aborts it, and the next cycle is idle and silent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe; sampled only while idle |
| code | input | 8 | Checkpoint value, captured on an accepted start |
| spk | output | 1 | Speaker enable, high during a beep |
| busy | output | 1 | High while a pattern is playing |
| done | output | 1 | One-cycle pulse after the last beep |

## Verification
An accepted start shows on `spk` and `busy` one edge later. The last beep is followed directly by `done`, with no idle cycle in between. A reset clears all outputs one edge after it is sampled. The bench model expands each accepted start into an exact per-cycle queue of expected `spk`, `busy` and `done` values. It pops one entry per cycle and compares it at the falling edge, so every result is checked in the cycle it is due. A second pass counts the beeps per run from the observed `spk`, splitting runs at silences of at least `GROUP_CYC`, and compares the decoded digits with the expected pattern.

// File: rtl/beep_code_seq.sv
module beep_code_seq #(
  parameter int ON_CYC    = 4,
  parameter int INTRA_CYC = 3,
  parameter int GROUP_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] code,
  output logic       spk,
  output logic       busy,
  output logic       done
);
  localparam int MAXC = (ON_CYC > GROUP_CYC) ? ON_CYC : GROUP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ON, S_GAP_IN, S_GAP_GRP} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [7:0]    cap;
  logic [1:0]    grp;
  logic [1:0]    left;

  assign spk  = (st == S_ON);
  assign busy = (st != S_IDLE);

  wire [1:0] next_field = cap[5 - 2*grp -: 2];
  wire       cnt_end    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      cap  <= '0;
      grp  <= '0;
      left <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cap  <= code;
          grp  <= '0;
          left <= code[7:6];
          cnt  <= CW'(ON_CYC - 1);
          st   <= S_ON;
        end
        S_ON: if (!cnt_end) cnt <= cnt - 1'b1;
          else if (left != 2'd0) begin
            left <= left - 1'b1;
            cnt  <= CW'(INTRA_CYC - 1);
            st   <= S_GAP_IN;
          end else if (grp == 2'd3) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            left <= next_field;
            grp  <= grp + 1'b1;
            cnt  <= CW'(GROUP_CYC - 1);
            st   <= S_GAP_GRP;
          end
        S_GAP_IN, S_GAP_GRP: if (!cnt_end) cnt <= cnt - 1'b1;
          else begin
            cnt <= CW'(ON_CYC - 1);
            st  <= S_ON;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !spk && !done)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && !spk)); // R7
  AST_DONE_AFTER_BEEP: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(spk)); // R7
  AST_SPK_IN_BUSY: assert property (@(posedge clk) disable iff (rst) spk |-> busy); // R2
  AST_BUSY_STARTS_LOUD: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> spk); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && !spk && start) |=> busy); // R8
endmodule

// File: tb/beep_code_seq_bench.sv
module beep_code_seq_bench;
  localparam int ONC = 3, INC = 2, GPC = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] code = 8'h00;
  logic spk, busy, done;

  always #5 clk = ~clk;

  beep_code_seq #(.ON_CYC(ONC), .INTRA_CYC(INC), .GROUP_CYC(GPC)) u_beep_code_seq (
    .clk(clk), .rst(rst), .start(start), .code(code),
    .spk(spk), .busy(busy), .done(done));

  int q[$];
  int obs[$];
  int nvec = 0, nbad = 0, lowrun = 0, cycles = 0;
  logic prev_spk = 1'b0;
  logic saw_done;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nbad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic expand(input logic [7:0] c);
    for (int g = 3; g >= 0; g--) begin
      int n = c[2*g +: 2] + 1;
      for (int b = 0; b < n; b++) begin
        for (int k = 0; k < ONC; k++) q.push_back(1);
        if (b < n - 1) for (int k = 0; k < INC; k++) q.push_back(0);
      end
      if (g > 0) for (int k = 0; k < GPC; k++) q.push_back(0);
    end
    q.push_back(2);
  endtask

  task automatic step(input logic s, input logic [7:0] c, input logic r);
    int e;
    logic es, eb, ed;
    @(negedge clk);
    e  = (q.size() != 0) ? q.pop_front() : -1;
    es = (e == 1); eb = (e == 0 || e == 1); ed = (e == 2);
    nvec++;
    if (spk !== es) begin
      nbad++; $display("FAIL R2/R6 spk: actual %b expected %b", spk, es);
    end else if (busy !== eb) begin
      nbad++; $display("FAIL R1/R7/R8/R9 busy: actual %b expected %b", busy, eb);
    end else if (done !== ed) begin
      nbad++; $display("FAIL R7 done: actual %b expected %b", done, ed);
    end
    if (done) saw_done = 1'b1;
    if (spk && !prev_spk) begin
      if (obs.size() == 0 || lowrun >= GPC) obs.push_back(1);
      else obs[obs.size()-1]++;
    end
    lowrun   = spk ? 0 : lowrun + 1;
    prev_spk = spk;
    rst = r; start = s; code = c;
    if (r) q.delete();
    else if (s && !eb) expand(c);
  endtask

  task automatic play(input logic [7:0] c, input string tag, input logic poke);
    string got, want;
    int n = 0;
    obs.delete(); lowrun = 0; prev_spk = 1'b0; saw_done = 1'b0;
    step(1'b1, c, 1'b0);
    while (!saw_done && n < 2000) begin
      n++;
      step(poke && (n == 7), ~c, 1'b0);
    end
    step(1'b0, 8'h00, 1'b0);
    want = $sformatf("%0d-%0d-%0d-%0d", c[7:6]+1, c[5:4]+1, c[3:2]+1, c[1:0]+1);
    got = "";
    foreach (obs[i]) got = {got, (i == 0) ? "" : "-", $sformatf("%0d", obs[i])};
    nvec++;
    if (got != want) begin
      nbad++; $display("FAIL %s code %h: actual %s expected %s", tag, c, got, want);
    end
  endtask

  initial begin
    step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    step(1'b1, 8'hFF, 1'b1);
    repeat (3) step(1'b0, 8'h00, 1'b0);            // R1 idle after reset
    play(8'h4B, "R3", 1'b0);
    play(8'h20, "R4", 1'b0);
    play(8'h16, "R4", 1'b0);
    play(8'h00, "R5", 1'b0);
    play(8'hFF, "R5", 1'b0);
    play(8'hE4, "R3/R6", 1'b0);
    play(8'h1B, "R8", 1'b1);                        // start while busy ignored
    step(1'b1, 8'h55, 1'b0);
    repeat (2) step(1'b0, 8'h55, 1'b0);             // R7 done cycle precedes restart
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b1);                        // R9 reset mid-sequence
    repeat (5) step(1'b0, 8'h00, 1'b0);
    play(8'hA5, "R2", 1'b0);
    step(1'b1, 8'h03, 1'b0);
    while (q.size() != 0) step(1'b0, 8'h00, 1'b0);
    repeat (3) step(1'b0, 8'h00, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule